// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block sits between the comparators of a multi-timer event counter and the interrupt fabric of the chip. Each timer raises a one-cycle fire strobe when its comparator matches. The block then decides, from that timer's configuration word, how the event is delivered. It can issue a message-signalled interrupt, pulse one of 32 interrupt lines, or latch a status bit and hold a line high. A fire strobe may also be dropped entirely.

Each timer owns a 64-bit configuration word and a 64-bit message routing word. A shared select, data and byte-lane mask bus writes both. Capability fields in the configuration word are read-only. The upper half of that word holds the set of lines the timer may be routed to, and this set follows from the pin count of the downstream interrupt controller. A write-one-to-clear status register collects the level-triggered events. When a configuration write makes a latched level assertion stale, the block clears it by itself.

Configuration bit map used throughout: bit 1 trigger type (0 edge, 1 level), bit 2 interrupt enable, bit 3 periodic mode (stored only), bit 4 periodic-capable (read-only, 1), bit 5 counter-size (read-only, 0), bit 6 value-set (stored only), bit 8 32-bit mode (always 0), bits 13:9 route, bit 14 message enable, bit 15 message-capable (read-only, 1), bits 63:32 allowed-line mask (read-only).

Top module: `evt_irq_router`

## Requirements
- R1: A fire strobe for a timer whose interrupt enable (bit 2) is 0 has no effect on the lines, the message request or the status register.
- R2: A fire strobe for a timer whose status bit is already set has no effect: no new pulse, no message, the line stays high.
- R3: A timer is in message mode only when bit 15 and bit 14 are both 1. An accepted fire then raises msg_req_o for one cycle, in the cycle after the strobe, with msg_addr_o = routing word bits 63:32 and msg_data_o = bits 31:0. When several message-mode timers fire together, the lowest-numbered timer is delivered.
- R4: A route of 0, or any route while in message mode, connects the timer to no line: an accepted fire drives no bit of irq_o.
- R5: With trigger type 0 and a nonzero route r, an accepted fire drives irq_o[r] high for exactly one cycle, in the cycle after the strobe, and leaves the status bit at 0.
- R6: With trigger type 1 and a nonzero route r, an accepted fire sets status bit n of sts_o in the cycle after the strobe, and irq_o[r] stays high while that bit is set. A line stays high while any level-asserting timer routed to it remains set.
- R7: Writing the status register clears exactly the bits written as 1; the line of a cleared timer drops in the same cycle the bit clears. Bits written as 0 are unchanged.
- R8: After a configuration write, a nonzero route whose bit in the allowed mask (bits 63:32) is 0 is stored as 0.
- R9: A configuration write leaves bits 63:32, 15, 5 and 4 unchanged, and bit 8 always reads 0; the other bits take the masked write data.
- R10: After reset every configuration word equals {allowed mask, 32'h0000_8010}. The allowed mask is 0xFF00_0000 for 32 or more controller pins, the top four pins (0xF shifted left by pins-4) for 20 to 31 pins, and 0 below 20 pins. With the default 24 pins it is 0x00F0_0000.
- R11: A configuration write clears a set status bit, and drops its line, when the new word has interrupt enable 0, trigger type 0, message mode on, or a route different from the old one; any other change keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fire_i | input | NUM_TIMERS | Per-timer fire strobes |
| cfg_we_i | input | 1 | Write the selected timer's configuration word |
| route_we_i | input | 1 | Write the selected timer's message routing word |
| sel_i | input | IDX_W | Timer select for writes and configuration read |
| wdata_i | input | 64 | Write data |
| wmask_i | input | 64 | Bit mask of the write; masked-off bits are kept |
| sts_we_i | input | 1 | Write-one-to-clear strobe for the status register |
| sts_wdata_i | input | NUM_TIMERS | Status bits to clear |
| cfg_rdata_o | output | 64 | Configuration word of the selected timer |
| sts_o | output | NUM_TIMERS | Status register |
| irq_o | output | 32 | Interrupt lines |
| msg_req_o | output | 1 | One-cycle message interrupt request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The assertions assume that a timer never receives a configuration write and a fire strobe in the same cycle, and that sel_i always names an existing timer. Under these assumptions, a latched status bit always matches an enabled, level-type, line-routed configuration. The stimulus writes configuration and fires in separate cycles and keeps the select within the eight timers. It only fires a level timer when the route it was written with has been accepted.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
// Shared bit positions and helpers for the event timer interrupt router.
// Assumes a 64-bit configuration word with the route in bits 13:9.
package evt_irq_pkg;
    localparam int LINES     = 32;
    localparam int RT_W      = 5;
    localparam int TRIG_B    = 1;
    localparam int IE_B      = 2;
    localparam int PCAP_B    = 4;
    localparam int SIZE_B    = 5;
    localparam int M32_B     = 8;
    localparam int RT_LO     = 9;
    localparam int RT_HI     = 13;
    localparam int MEN_B     = 14;
    localparam int MCAP_B    = 15;

    localparam logic [63:0] RO_MASK = 64'hFFFF_FFFF_0000_0000
                                    | (64'd1 << MCAP_B)
                                    | (64'd1 << SIZE_B)
                                    | (64'd1 << PCAP_B);

    // Lines a timer may drive, from the downstream controller pin count.
    function automatic logic [31:0] allowed_lines(input int pins);
        if (pins >= 32)      return 32'hFF00_0000;
        else if (pins >= 20) return 32'hF << (pins - 4);
        else                 return 32'h0;
    endfunction
endpackage

// File: rtl/evt_irq_timer.sv
`timescale 1ns/1ps
// One timer's configuration, routing word and status bit.
// Decides the delivery of each fire strobe and validates configuration
// writes. Assumes no configuration write and fire in the same cycle.
module evt_irq_timer
    import evt_irq_pkg::*;
#(
    parameter logic [31:0] ALLOWED = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              cfg_we_i,
    input  logic              route_we_i,
    input  logic [63:0]       wdata_i,
    input  logic [63:0]       wmask_i,
    input  logic              sts_clr_i,
    output logic [63:0]       cfg_o,
    output logic [63:0]       route_word_o,
    output logic              sts_o,
    output logic [RT_W-1:0]   line_o,
    output logic              msg_fire_o,
    output logic              edge_fire_o
);
    localparam logic [63:0] RST_CFG = {ALLOWED, 32'h0}
                                    | (64'd1 << MCAP_B) | (64'd1 << PCAP_B);

    logic [63:0]     cfg_q, route_q, cfg_nxt, merged;
    logic            sts_q, msg_mode, accept, lvl_set, cfg_clr;
    logic [RT_W-1:0] new_rt;

    // Delivery decision for a fire strobe.
    always_comb begin
        msg_mode    = cfg_q[MEN_B] && cfg_q[MCAP_B];
        line_o      = msg_mode ? '0 : cfg_q[RT_HI:RT_LO];
        accept      = fire_i && cfg_q[IE_B] && !sts_q;
        msg_fire_o  = accept && msg_mode;
        edge_fire_o = accept && !msg_mode && (line_o != '0) && !cfg_q[TRIG_B];
        lvl_set     = accept && !msg_mode && (line_o != '0) && cfg_q[TRIG_B];
    end

    // Next configuration word: merge, protect read-only bits, validate route.
    always_comb begin
        merged  = (cfg_q & ~wmask_i) | (wdata_i & wmask_i);
        cfg_nxt = (merged & ~(RO_MASK | (64'd1 << M32_B))) | (cfg_q & RO_MASK);
        new_rt  = cfg_nxt[RT_HI:RT_LO];
        if (new_rt != '0 && !ALLOWED[new_rt])
            cfg_nxt[RT_HI:RT_LO] = '0;
        cfg_clr = cfg_we_i && sts_q &&
                  (!cfg_nxt[IE_B] || !cfg_nxt[TRIG_B] ||
                   (cfg_nxt[MEN_B] && cfg_nxt[MCAP_B]) ||
                   (cfg_nxt[RT_HI:RT_LO] != cfg_q[RT_HI:RT_LO]));
    end

    // Configuration and routing word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= RST_CFG;
            route_q <= '0;
        end else begin
            if (cfg_we_i)   cfg_q   <= cfg_nxt;
            if (route_we_i) route_q <= (route_q & ~wmask_i) | (wdata_i & wmask_i);
        end
    end

    // Status bit: cleared by software or stale config, set by a level fire.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sts_q <= 1'b0;
        else if (sts_clr_i || cfg_clr) sts_q <= 1'b0;
        else if (lvl_set)              sts_q <= 1'b1;
    end

    assign cfg_o        = cfg_q;
    assign route_word_o = route_q;
    assign sts_o        = sts_q;

    assert_fire_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i && !cfg_q[IE_B] && !sts_q |=> !sts_q);
    assert_fire_while_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q && fire_i && !sts_clr_i && !cfg_we_i |=> sts_q);
    assert_route_allowed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[RT_HI:RT_LO] != '0 |-> ALLOWED[cfg_q[RT_HI:RT_LO]]);
    assert_ro_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_q & RO_MASK) == ($past(cfg_q) & RO_MASK)) && !cfg_q[M32_B]);
    assert_status_consistent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q |-> cfg_q[IE_B] && cfg_q[TRIG_B] && !msg_mode && cfg_q[RT_HI:RT_LO] != '0);
endmodule

// File: rtl/evt_irq_msg_arb.sv
`timescale 1ns/1ps
// Picks the lowest-numbered timer among simultaneous message fires and
// registers its address and data for one cycle. Others are dropped.
module evt_irq_msg_arb #(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_i,
    input  logic [N-1:0][63:0] words_i,
    output logic              req_o,
    output logic [31:0]       addr_o,
    output logic [31:0]       data_o
);
    int pick;

    // Lowest index wins.
    always_comb begin
        pick = 0;
        for (int i = N - 1; i >= 0; i--)
            if (req_i[i]) pick = i;
    end

    // Registered one-cycle message request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            req_o <= |req_i;
            if (|req_i) begin
                addr_o <= words_i[pick][63:32];
                data_o <= words_i[pick][31:0];
            end
        end
    end

    assert_msg_follows_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        |req_i |=> req_o);
endmodule

// File: rtl/evt_irq_lines.sv
`timescale 1ns/1ps
// Builds the 32 interrupt lines: registered one-cycle edge pulses ORed
// with level lines taken directly from the status bits, so a cleared
// status bit drops its line in the same cycle. Route 0 drives nothing.
module evt_irq_lines
    import evt_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           edge_i,
    input  logic [N-1:0]           sts_i,
    input  logic [N-1:0][RT_W-1:0] line_i,
    output logic [LINES-1:0]       irq_o
);
    logic [LINES-1:0] pulse_q, pulse_nxt, level;

    // Decode routes of edge fires and held levels.
    always_comb begin
        pulse_nxt = '0;
        level     = '0;
        for (int i = 0; i < N; i++) begin
            if (edge_i[i] && line_i[i] != '0) pulse_nxt[line_i[i]] = 1'b1;
            if (sts_i[i]  && line_i[i] != '0) level[line_i[i]]     = 1'b1;
        end
    end

    // One-cycle pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_nxt;
    end

    assign irq_o = pulse_q | level;

    assert_line_zero_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o[0]);
endmodule

// File: rtl/evt_irq_router.sv
`timescale 1ns/1ps
// Top of the event timer interrupt router: per-timer delivery units,
// message arbitration and line assembly. Assumes sel_i names a timer.
module evt_irq_router
    import evt_irq_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int PIN_COUNT  = 24,
    localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TIMERS-1:0] fire_i,
    input  logic                  cfg_we_i,
    input  logic                  route_we_i,
    input  logic [IDX_W-1:0]      sel_i,
    input  logic [63:0]           wdata_i,
    input  logic [63:0]           wmask_i,
    input  logic                  sts_we_i,
    input  logic [NUM_TIMERS-1:0] sts_wdata_i,
    output logic [63:0]           cfg_rdata_o,
    output logic [NUM_TIMERS-1:0] sts_o,
    output logic [31:0]           irq_o,
    output logic                  msg_req_o,
    output logic [31:0]           msg_addr_o,
    output logic [31:0]           msg_data_o
);
    localparam logic [31:0] ALLOWED = allowed_lines(PIN_COUNT);

    logic [63:0]                    cfg_arr [NUM_TIMERS];
    logic [NUM_TIMERS-1:0][63:0]    words;
    logic [NUM_TIMERS-1:0][RT_W-1:0] lines;
    logic [NUM_TIMERS-1:0]          msg_fire, edge_fire, sts_w;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        evt_irq_timer #(.ALLOWED(ALLOWED)) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .fire_i      (fire_i[g]),
            .cfg_we_i    (cfg_we_i && (sel_i == IDX_W'(g))),
            .route_we_i  (route_we_i && (sel_i == IDX_W'(g))),
            .wdata_i     (wdata_i),
            .wmask_i     (wmask_i),
            .sts_clr_i   (sts_we_i && sts_wdata_i[g]),
            .cfg_o       (cfg_arr[g]),
            .route_word_o(words[g]),
            .sts_o       (sts_w[g]),
            .line_o      (lines[g]),
            .msg_fire_o  (msg_fire[g]),
            .edge_fire_o (edge_fire[g])
        );

        assert_level_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sts_w[g] |-> irq_o[lines[g]]);
    end

    evt_irq_msg_arb #(.N(NUM_TIMERS)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (msg_fire),
        .words_i(words),
        .req_o  (msg_req_o),
        .addr_o (msg_addr_o),
        .data_o (msg_data_o)
    );

    evt_irq_lines #(.N(NUM_TIMERS)) u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(edge_fire),
        .sts_i (sts_w),
        .line_i(lines),
        .irq_o (irq_o)
    );

    assign cfg_rdata_o = cfg_arr[sel_i];
    assign sts_o       = sts_w;
endmodule

// File: tb/evt_irq_router_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs of each step,
// the monitor pops and compares them 5 ns after the following rising edge.
module evt_irq_router_tb;
    localparam int N = 8;
    localparam logic [63:0] BASE = 64'h00F0_0000_0000_8010;
    localparam logic [63:0] LOW  = 64'h0000_0000_FFFF_FFFF;

    typedef struct {
        string       tag;
        logic [31:0] irq;
        logic        req;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  sts;
        logic        chk;
        logic [63:0] cfg;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] fire_i = '0, sts_wdata_i = '0;
    logic cfg_we_i = 1'b0, route_we_i = 1'b0, sts_we_i = 1'b0;
    logic [2:0]  sel_i = '0;
    logic [63:0] wdata_i = '0, wmask_i = '0;
    logic [63:0] cfg_rdata_o;
    logic [N-1:0] sts_o;
    logic [31:0] irq_o, msg_addr_o, msg_data_o;
    logic msg_req_o;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    evt_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .cfg_we_i(cfg_we_i),
        .route_we_i(route_we_i), .sel_i(sel_i), .wdata_i(wdata_i),
        .wmask_i(wmask_i), .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
        .cfg_rdata_o(cfg_rdata_o), .sts_o(sts_o), .irq_o(irq_o),
        .msg_req_o(msg_req_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    // Monitor: compare one expected item per rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                checks++;
                bad = (irq_o !== e.irq) || (msg_req_o !== e.req) || (sts_o !== e.sts)
                   || (e.req && (msg_addr_o !== e.addr || msg_data_o !== e.data))
                   || (e.chk && cfg_rdata_o !== e.cfg);
                if (bad) begin
                    fails++;
                    $display("FAIL %s: actual irq=%h req=%b addr=%h data=%h sts=%h cfg=%h expected irq=%h req=%b addr=%h data=%h sts=%h cfg=%h",
                             e.tag, irq_o, msg_req_o, msg_addr_o, msg_data_o, sts_o, cfg_rdata_o,
                             e.irq, e.req, e.addr, e.data, e.sts, e.cfg);
                end
            end
        end
    end

    task automatic expect_step(input string tag, input logic [31:0] irq, input logic req,
                               input logic [31:0] addr, input logic [31:0] data,
                               input logic [7:0] sts, input logic chk, input logic [63:0] cfg);
        exp_t e;
        e.tag = tag; e.irq = irq; e.req = req; e.addr = addr; e.data = data;
        e.sts = sts; e.chk = chk; e.cfg = cfg;
        q.push_back(e);
        @(negedge clk);
        fire_i = '0; cfg_we_i = 1'b0; route_we_i = 1'b0; sts_we_i = 1'b0;
    endtask

    task automatic wr_cfg(input int t, input logic [63:0] d, input logic [63:0] m);
        sel_i = 3'(t); wdata_i = d; wmask_i = m; cfg_we_i = 1'b1;
    endtask

    task automatic wr_route(input int t, input logic [63:0] d);
        sel_i = 3'(t); wdata_i = d; wmask_i = '1; route_we_i = 1'b1;
    endtask

    task automatic w1c(input logic [7:0] m);
        sts_wdata_i = m; sts_we_i = 1'b1;
    endtask

    // Level config write on timer 4 with check of the stored word.
    task automatic t4_cfg(input string tag, input logic [31:0] bits, input logic [7:0] sts,
                          input logic [31:0] irq);
        wr_cfg(4, {32'h0, bits}, LOW);
        expect_step(tag, irq, 0, 0, 0, sts, 1, BASE | {32'h0, bits});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values
        sel_i = 0; expect_step("R10 reset t0", 0, 0, 0, 0, 0, 1, BASE);
        sel_i = 7; expect_step("R10 reset t7", 0, 0, 0, 0, 0, 1, BASE);
        // R1: disabled timer ignores fire
        wr_cfg(0, 64'h2800, LOW); expect_step("R1 cfg", 0, 0, 0, 0, 0, 1, BASE | 64'h2800);
        fire_i = 8'h01; expect_step("R1 fire ignored", 0, 0, 0, 0, 0, 0, 0);
        // R5: edge pulse on line 20, one cycle
        wr_cfg(0, 64'h2804, LOW); expect_step("R5 cfg", 0, 0, 0, 0, 0, 1, BASE | 64'h2804);
        fire_i = 8'h01; expect_step("R5 pulse", 32'h1 << 20, 0, 0, 0, 0, 0, 0);
        expect_step("R5 pulse ends", 0, 0, 0, 0, 0, 0, 0);
        // R8: route 5 not allowed -> 0; R4: unrouted fire does nothing
        wr_cfg(1, 64'h0A06, LOW); sel_i = 1;
        expect_step("R8 route forced 0", 0, 0, 0, 0, 0, 1, BASE | 64'h6);
        fire_i = 8'h02; expect_step("R4 unrouted fire", 0, 0, 0, 0, 0, 0, 0);
        // R9: all-ones write keeps read-only bits, bit 8 zero, route 31 rejected
        wr_cfg(2, '1, '1); expect_step("R9 ro bits", 0, 0, 0, 0, 0, 1, 64'h00F0_0000_FFFF_C0DF);
        // R3: message delivery
        wr_route(2, 64'hFEE0_1000_0000_0041); expect_step("R3 route word", 0, 0, 0, 0, 0, 0, 0);
        fire_i = 8'h04; expect_step("R3 message", 0, 1, 32'hFEE0_1000, 32'h41, 0, 0, 0);
        expect_step("R3 message ends", 0, 0, 0, 0, 0, 0, 0);
        wr_cfg(3, 64'h4004, LOW); expect_step("R3 cfg t3", 0, 0, 0, 0, 0, 1, BASE | 64'h4004);
        wr_route(3, 64'hFEE0_2000_0000_0052); expect_step("R3 route t3", 0, 0, 0, 0, 0, 0, 0);
        fire_i = 8'h0C; expect_step("R3 lowest wins", 0, 1, 32'hFEE0_1000, 32'h41, 0, 0, 0);
        fire_i = 8'h08; expect_step("R3 t3 alone", 0, 1, 32'hFEE0_2000, 32'h52, 0, 0, 0);
        // R4: message mode ignores route 21
        wr_cfg(3, 64'h6A04, LOW); expect_step("R4 cfg", 0, 0, 0, 0, 0, 1, BASE | 64'h6A04);
        fire_i = 8'h08; expect_step("R4 msg no line", 0, 1, 32'hFEE0_2000, 32'h52, 0, 0, 0);
        // R6 / R2 / R7: level on line 21
        sel_i = 4;
        t4_cfg("R6 cfg", 32'h2A06, 0, 0);
        fire_i = 8'h10; expect_step("R6 level set", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        expect_step("R6 level held", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        fire_i = 8'h10; expect_step("R2 refire ignored", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        w1c(8'hEF); expect_step("R7 zeros keep", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        w1c(8'h10); expect_step("R7 clear", 0, 0, 0, 0, 0, 0, 0);
        // R11: config-change clears
        fire_i = 8'h10; expect_step("R11 set a", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        t4_cfg("R11 unrelated keeps", 32'h2A0E, 8'h10, 32'h1 << 21);
        t4_cfg("R11 ie off clears", 32'h2A0A, 0, 0);
        t4_cfg("R11 restore b", 32'h2A06, 0, 0);
        fire_i = 8'h10; expect_step("R11 set b", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        t4_cfg("R11 edge clears", 32'h2A04, 0, 0);
        t4_cfg("R11 restore c", 32'h2A06, 0, 0);
        fire_i = 8'h10; expect_step("R11 set c", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        t4_cfg("R11 msg clears", 32'h6A06, 0, 0);
        t4_cfg("R11 restore d", 32'h2A06, 0, 0);
        fire_i = 8'h10; expect_step("R11 set d", 32'h1 << 21, 0, 0, 0, 8'h10, 0, 0);
        t4_cfg("R11 route clears", 32'h2C06, 0, 0);
        // R6 shared line: t4 and t5 on line 22
        wr_cfg(5, 64'h2C06, LOW); sel_i = 5;
        expect_step("R6 cfg t5", 0, 0, 0, 0, 0, 1, BASE | 64'h2C06);
        fire_i = 8'h30; expect_step("R6 two levels", 32'h1 << 22, 0, 0, 0, 8'h30, 0, 0);
        w1c(8'h10); expect_step("R7 shared stays", 32'h1 << 22, 0, 0, 0, 8'h20, 0, 0);
        w1c(8'h20); expect_step("R7 shared drops", 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule